// File: doc/BRIEF.md
# Mailbox Request Initiator Engine

This engine is the requesting side of a 256-bit shared mailbox. It issues two commands. An open command takes four 64-bit queue base addresses, a vector index and a reset flag. A close command takes only the reset flag.

On a start pulse the engine first checks the operands and waits until it owns the mailbox. It then builds the message and writes it as 32-bit dwords. Next it polls the control dword until the other side hands ownership back, and checks the response found there. It ends with a one-cycle done pulse that carries a result code.

Polling paces itself with a programmable number of idle cycles between samples. The number of samples it takes before giving up is a parameter. The page size is a parameter as well: `PAGE_SHIFT`, 12 by default, turns addresses into frame numbers.

Top module: `mbox_req_engine`

## Requirements
- R1: After reset `busy_o`, `done_o` and `wr_en_o` are low. Every command ends with `done_o` high for exactly one cycle, with `err_o` valid in that cycle: 0 ok, 1 invalid, 2 timeout, 3 protocol.
- R2: An open command whose address has any of its low `PAGE_SHIFT` bits set, or whose vector index exceeds 16 bits, ends with code 1 and performs no mailbox write. A close command does not check the addresses or the vector.
- R3: Before writing, the engine samples `mbox_d7_i` and writes nothing while bit 31 is set. After each sample that finds bit 31 set it waits `poll_gap_i` cycles before the next sample.
- R4: If `MAX_POLLS` consecutive samples in one polling phase find the mailbox still owned, the command ends with code 2. The first of these samples comes two cycles after start is accepted. From a start seen at clock edge s, done is registered at edge s+2+(MAX_POLLS-1)*(poll_gap_i+1).
- R5: Each address is shifted right by `PAGE_SHIFT` to give a 52-bit frame number. The low 48 bits of the four frame numbers (eq, cq, rq, sq) occupy message bits 0-47, 48-95, 96-143 and 144-191 in that order, least significant byte first.
- R6: Message bits 192-207 hold bits 51:48 of each frame number as nibbles 0-3 in eq, cq, rq, sq order. Bits 208-223 hold the vector index.
- R7: An open command writes dwords 0 to 7 on consecutive cycles in ascending order. A close command writes only dword 7. Dword i carries message bits 32i+31 down to 32i.
- R8: Dword 7 is the header. Bits 2:0 hold the type (1 open, 2 close), bits 5:3 hold version 0, bit 7 is direction 0, bits 15:8 are status 0, bit 24 is the reset flag, and bit 31 is 0.
- R9: Once bit 31 reads clear after the writes, the response passes only if bits 2:0 equal the requested type, bits 5:3 are not greater than the requested version, bit 7 is 1 and bits 15:8 are 0. Any other response ends with code 3.
- R10: With the reset flag set, reading 0xFFFFFFFF during response polling ends the command with code 0. Without the flag that value counts as still owned.
- R11: A start pulse while `busy_o` is high is ignored; the running command's writes and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse |
| cmd_i | input | 1 | 0 open, 1 close |
| reset_flag_i | input | 1 | Reset request carried in the header |
| eq_addr_i | input | 64 | Event queue base address |
| cq_addr_i | input | 64 | Completion queue base address |
| rq_addr_i | input | 64 | Receive queue base address |
| sq_addr_i | input | 64 | Send queue base address |
| vec_idx_i | input | 32 | Interrupt vector index |
| poll_gap_i | input | 16 | Idle cycles between polls |
| mbox_d7_i | input | 32 | Current mailbox control dword |
| wr_en_o | output | 1 | Mailbox write strobe |
| wr_idx_o | output | 3 | Dword index being written |
| wr_data_o | output | 32 | Dword data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 2 | Result code, valid with done |

## Verification
The assertions check on every cycle that done is a single-cycle pulse and that an idle engine accepts a start. They also check that writes occur only while busy and only after an owner-clear sample, that dwords ascend without a gap, and that the header dword has legal fixed fields. Only the bench scenarios can show the rest. That covers the exact bit packing of frames, nibbles and vector, the result codes for each malformed response, the all-ones shortcut with and without the reset flag, the timeout latency, and that a start while busy changes nothing.

// File: rtl/mbox_req_pkg.sv
package mbox_req_pkg;
  typedef enum logic [1:0] {RES_OK = 2'd0, RES_INVALID = 2'd1, RES_TIMEOUT = 2'd2, RES_PROTO = 2'd3} res_e;
  typedef enum logic {CMD_OPEN = 1'b0, CMD_CLOSE = 1'b1} cmd_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_OWN, ST_WRITE, ST_RESP} st_e;

  localparam logic [2:0] KIND_OPEN  = 3'd1;
  localparam logic [2:0] KIND_CLOSE = 3'd2;
  localparam logic [2:0] REQ_VER    = 3'd0;

  typedef struct packed {
    logic       owner;
    logic [5:0] rsvd3;
    logic       rst_req;
    logic [7:0] rsvd2;
    logic [7:0] status;
    logic       dir;
    logic       rsvd1;
    logic [2:0] ver;
    logic [2:0] kind;
  } hdr_t;

  function automatic hdr_t make_hdr(input logic close, input logic rst_req);
    hdr_t h;
    h         = '0;
    h.kind    = close ? KIND_CLOSE : KIND_OPEN;
    h.ver     = REQ_VER;
    h.rst_req = rst_req;
    return h;
  endfunction
endpackage

// File: rtl/mbox_pack.sv
module mbox_pack
  import mbox_req_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int FRAME_W = 52,
  parameter int LOW_W   = 48,
  parameter int VEC_W   = 16,
  parameter int MSG_W   = 256
) (
  input  logic [NQ-1:0][FRAME_W-1:0] frame_i,
  input  logic [VEC_W-1:0]           vec_i,
  input  hdr_t                       hdr_i,
  output logic [MSG_W-1:0]           msg_o
);
  localparam int HI_W     = FRAME_W - LOW_W;
  localparam int HI_BASE  = NQ * LOW_W;
  localparam int VEC_BASE = HI_BASE + NQ * HI_W;
  localparam int HDR_BASE = VEC_BASE + VEC_W;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign msg_o[q*LOW_W +: LOW_W]        = frame_i[q][LOW_W-1:0];
    assign msg_o[HI_BASE + q*HI_W +: HI_W] = frame_i[q][FRAME_W-1:LOW_W];
  end

  assign msg_o[VEC_BASE +: VEC_W] = vec_i;
  assign msg_o[HDR_BASE +: 32]    = hdr_i;
endmodule

// File: rtl/mbox_rsp_check.sv
module mbox_rsp_check
  import mbox_req_pkg::*;
(
  input  logic [2:0] exp_kind_i,
  input  logic [2:0] kind_i,
  input  logic [2:0] ver_i,
  input  logic       dir_i,
  input  logic [7:0] status_i,
  output logic       pass_o
);
  // older versions are acceptable, newer are not
  assign pass_o = (kind_i == exp_kind_i) && (ver_i <= REQ_VER) && dir_i && (status_i == 8'd0);
endmodule

// File: rtl/mbox_poll_timer.sv
module mbox_poll_timer #(
  parameter int MAX_POLLS = 20000,
  parameter int GAP_W     = 16,
  localparam int CNT_W    = $clog2(MAX_POLLS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             miss_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             ready_o,
  output logic             last_o
);
  logic [CNT_W-1:0] poll_q;
  logic [GAP_W-1:0] gap_q;

  assign ready_o = (gap_q == '0);
  assign last_o  = (poll_q == CNT_W'(MAX_POLLS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      poll_q <= '0;
      gap_q  <= '0;
    end else if (clear_i) begin
      poll_q <= '0;
      gap_q  <= '0;
    end else if (miss_i) begin
      poll_q <= poll_q + CNT_W'(1);
      gap_q  <= gap_i;
    end else if (!ready_o) begin
      gap_q <= gap_q - GAP_W'(1);
    end
  end
endmodule

// File: rtl/mbox_req_engine.sv
module mbox_req_engine
  import mbox_req_pkg::*;
#(
  parameter int PAGE_SHIFT = 12,
  parameter int MAX_POLLS  = 20000,
  parameter int GAP_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmd_i,
  input  logic             reset_flag_i,
  input  logic [63:0]      eq_addr_i,
  input  logic [63:0]      cq_addr_i,
  input  logic [63:0]      rq_addr_i,
  input  logic [63:0]      sq_addr_i,
  input  logic [31:0]      vec_idx_i,
  input  logic [GAP_W-1:0] poll_gap_i,
  input  logic [31:0]      mbox_d7_i,
  output logic             wr_en_o,
  output logic [2:0]       wr_idx_o,
  output logic [31:0]      wr_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       err_o
);
  localparam int NQ       = 4;
  localparam int ADDR_W   = 64;
  localparam int FRAME_W  = 52;
  localparam int VEC_W    = 16;
  localparam int MSG_W    = 256;
  localparam int NDW      = MSG_W / 32;
  localparam int IDX_W    = $clog2(NDW);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NDW - 1);
  localparam logic [ADDR_W-1:0] PG_MASK = (ADDR_W'(1) << PAGE_SHIFT) - ADDR_W'(1);

  st_e                          state_q;
  logic                         close_q, rflag_q;
  logic [NQ-1:0][ADDR_W-1:0]    addr_q;
  logic [31:0]                  vec_q;
  logic [GAP_W-1:0]             gap_q;
  logic [IDX_W-1:0]             idx_q;
  logic                         done_q;
  res_e                         err_q;

  logic [NQ-1:0][FRAME_W-1:0]   frames;
  logic [MSG_W-1:0]             msg;
  logic [NQ-1:0]                misaligned;
  logic                         bad_args, rsp_pass, rsp_allones, owned;
  logic                         polling, t_ready, t_last, t_clear, t_miss;

  for (genvar q = 0; q < NQ; q++) begin : g_frame
    assign frames[q]     = addr_q[q][PAGE_SHIFT +: FRAME_W];
    assign misaligned[q] = (addr_q[q] & PG_MASK) != '0;
  end

  assign bad_args    = (|misaligned) || (vec_q[31:VEC_W] != '0);
  assign owned       = mbox_d7_i[31];
  assign rsp_allones = rflag_q && (&mbox_d7_i);

  mbox_pack #(
    .NQ(NQ), .FRAME_W(FRAME_W), .LOW_W(48), .VEC_W(VEC_W), .MSG_W(MSG_W)
  ) i_pack (
    .frame_i(frames),
    .vec_i  (vec_q[VEC_W-1:0]),
    .hdr_i  (make_hdr(close_q, rflag_q)),
    .msg_o  (msg)
  );

  mbox_rsp_check i_rsp (
    .exp_kind_i(close_q ? KIND_CLOSE : KIND_OPEN),
    .kind_i    (mbox_d7_i[2:0]),
    .ver_i     (mbox_d7_i[5:3]),
    .dir_i     (mbox_d7_i[7]),
    .status_i  (mbox_d7_i[15:8]),
    .pass_o    (rsp_pass)
  );

  assign polling = (state_q == ST_OWN) || (state_q == ST_RESP);
  assign t_clear = (state_q == ST_CHECK) || ((state_q == ST_WRITE) && (idx_q == LAST_IDX));
  assign t_miss  = polling && t_ready && owned && !((state_q == ST_RESP) && rsp_allones);

  mbox_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_W(GAP_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(t_clear),
    .miss_i (t_miss),
    .gap_i  (gap_q),
    .ready_o(t_ready),
    .last_o (t_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      close_q <= 1'b0;
      rflag_q <= 1'b0;
      addr_q  <= '0;
      vec_q   <= '0;
      gap_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= RES_OK;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          close_q <= cmd_i;
          rflag_q <= reset_flag_i;
          addr_q  <= {sq_addr_i, rq_addr_i, cq_addr_i, eq_addr_i};
          vec_q   <= vec_idx_i;
          gap_q   <= poll_gap_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!close_q && bad_args) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= RES_INVALID;
          end else begin
            state_q <= ST_OWN;
          end
        end
        ST_OWN: if (t_ready) begin
          if (!owned) begin
            state_q <= ST_WRITE;
            idx_q   <= close_q ? LAST_IDX : '0;
          end else if (t_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= RES_TIMEOUT;
          end
        end
        ST_WRITE: begin
          if (idx_q == LAST_IDX) state_q <= ST_RESP;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        ST_RESP: if (t_ready) begin
          if (rsp_allones || !owned) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= (rsp_allones || rsp_pass) ? RES_OK : RES_PROTO;
          end else if (t_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            err_q   <= RES_TIMEOUT;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = (state_q == ST_WRITE);
  assign wr_idx_o  = idx_q;
  assign wr_data_o = msg[idx_q*32 +: 32];
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/mbox_req_sva.sv
module mbox_req_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        wr_en_o,
  input logic [2:0]  wr_idx_o,
  input logic [31:0] wr_data_o,
  input logic [31:0] mbox_d7_i
);
  p_done_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  p_write_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (busy_o && !done_o));

  p_write_after_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !$past(wr_en_o)) |-> !$past(mbox_d7_i[31]));

  p_ascend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o != 3'd7) |=> (wr_en_o && wr_idx_o == $past(wr_idx_o) + 3'd1));

  p_header_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_idx_o == 3'd7) |->
      (!wr_data_o[31] && wr_data_o[15:7] == 9'd0 && wr_data_o[5:3] == 3'd0 &&
       (wr_data_o[2:0] == 3'd1 || wr_data_o[2:0] == 3'd2)));
endmodule

bind mbox_req_engine mbox_req_sva i_mbox_req_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .wr_en_o  (wr_en_o),
  .wr_idx_o (wr_idx_o),
  .wr_data_o(wr_data_o),
  .mbox_d7_i(mbox_d7_i)
);

// File: tb/test_mbox_req_engine.sv
`timescale 1ns/1ps
module test_mbox_req_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, cmd_i = 1'b0, reset_flag_i = 1'b0;
  logic [63:0] eq_addr_i = '0, cq_addr_i = '0, rq_addr_i = '0, sq_addr_i = '0;
  logic [31:0] vec_idx_i = '0;
  logic [15:0] poll_gap_i = '0;
  logic [31:0] mbox_d7_i;
  logic        wr_en_o, busy_o, done_o;
  logic [2:0]  wr_idx_o;
  logic [31:0] wr_data_o;
  logic [1:0]  err_o;

  always #5 clk_i = ~clk_i;

  mbox_req_engine i_mbox_req_engine (.*);

  int nchk = 0, nerr = 0, cyc = 0;

  // mailbox model
  logic [31:0] cfg_init = '0, cfg_rsp = '0;
  int          cfg_hold = 0, cfg_delay = 0;
  logic        cfg_load = 1'b0;
  logic [31:0] d7 = '0;
  int          hold_cnt = 0, rsp_cnt = 0;
  bit          rsp_pend = 0;
  assign mbox_d7_i = d7;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cfg_load) begin
      d7 <= cfg_init; hold_cnt <= cfg_hold; rsp_pend <= 0;
    end else if (wr_en_o && wr_idx_o == 3'd7) begin
      d7 <= wr_data_o | 32'h8000_0000; rsp_cnt <= cfg_delay; rsp_pend <= 1;
    end else if (rsp_pend) begin
      if (rsp_cnt == 0) begin d7 <= cfg_rsp; rsp_pend <= 0; end
      else rsp_cnt <= rsp_cnt - 1;
    end else if (hold_cnt > 0) begin
      hold_cnt <= hold_cnt - 1;
      if (hold_cnt == 1) d7[31] <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // per-clock reference comparison of the write stream
  logic [34:0] exp_q[$];
  bit  done_seen = 0, prev_done = 0;
  int  done_cnt = 0, done_cyc = 0;
  logic [1:0] done_err;

  always @(negedge clk_i) if (rst_ni) begin
    if (wr_en_o) begin
      if (exp_q.size() == 0) chk(0, "R2/R7 unexpected write", {29'd0, wr_idx_o, wr_data_o}, 0);
      else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        chk({wr_idx_o, wr_data_o} == e, "R5/R6/R7/R8 write stream", {29'd0, wr_idx_o, wr_data_o}, {29'd0, e});
      end
    end
    if (done_o) begin
      if (prev_done) chk(0, "R1 done longer than one cycle", 1, 0);
      done_seen = 1; done_cnt++; done_err = err_o; done_cyc = cyc;
    end
    prev_done = done_o;
  end

  // reference message builder, byte oriented
  task automatic build(input bit close, input bit rflag, input logic [63:0] a0, a1, a2, a3, input logic [31:0] vec);
    logic [7:0]  b[32];
    logic [63:0] f;
    logic [15:0] hi;
    logic [31:0] h;
    logic [63:0] addrs[4];
    addrs = '{a0, a1, a2, a3};
    hi = '0;
    for (int q = 0; q < 4; q++) begin
      f = addrs[q] >> 12;
      for (int k = 0; k < 6; k++) b[6*q+k] = f[8*k +: 8];
      hi = hi | (16'(f[51:48]) << (4*q));
    end
    b[24] = hi[7:0]; b[25] = hi[15:8]; b[26] = vec[7:0]; b[27] = vec[15:8];
    h = (close ? 32'd2 : 32'd1) | (32'(rflag) << 24);
    for (int k = 0; k < 4; k++) b[28+k] = h[8*k +: 8];
    for (int j = 0; j < 8; j++)
      if (!close || j == 7) exp_q.push_back({3'(j), b[4*j+3], b[4*j+2], b[4*j+1], b[4*j]});
  endtask

  int start_cyc;

  task automatic run(input string tag, input bit close, input bit rflag,
                     input logic [63:0] a0, a1, a2, a3, input logic [31:0] vec, input logic [15:0] gap,
                     input logic [31:0] init, input int hold, input logic [31:0] rsp, input int dly,
                     input bit writes, input logic [1:0] exp_err, input bit poke);
    exp_q.delete();
    if (writes) build(close, rflag, a0, a1, a2, a3, vec);
    @(negedge clk_i);
    cfg_init = init; cfg_hold = hold; cfg_rsp = rsp; cfg_delay = dly; cfg_load = 1;
    @(negedge clk_i);
    cfg_load = 0;
    cmd_i = close; reset_flag_i = rflag; eq_addr_i = a0; cq_addr_i = a1; rq_addr_i = a2; sq_addr_i = a3;
    vec_idx_i = vec; poll_gap_i = gap; done_seen = 0; done_cnt = 0; start_i = 1; start_cyc = cyc;
    @(negedge clk_i);
    start_i = 0;
    if (poke) begin
      @(negedge clk_i);
      cmd_i = ~close; eq_addr_i = 64'h123; start_i = 1;
      @(negedge clk_i);
      start_i = 0;
    end
    while (!done_seen) @(negedge clk_i);
    @(negedge clk_i);
    chk(done_err == exp_err, {tag, " result code"}, done_err, exp_err);
    chk(exp_q.size() == 0, {tag, " all writes seen"}, exp_q.size(), 0);
    chk(done_cnt == 1 && !busy_o, {tag, " R1 single done, idle"}, done_cnt, 1);
  endtask

  localparam logic [63:0] A0 = 64'h7123_4567_89AB_C000, A1 = 64'hF0E1_D2C3_B4A5_9000,
                          A2 = 64'h0000_0000_0000_1000, A3 = 64'h3FFF_FFFF_FFFF_F000;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk_i) if (cyc > 190000) begin
    nerr++; nchk++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !wr_en_o, "R1 reset state", {busy_o, done_o, wr_en_o}, 0);
    rst_ni = 1;
    // R5 R6 R7 R8 R9: open, immediate ownership
    run("R5 open ok", 0, 0, A0, A1, A2, A3, 32'h0000_BEEF, 0, 0, 0, 32'h81, 3, 1, 0, 0);
    // R3: ownership released late, with gap, reset flag in header
    run("R3 open after hold", 0, 1, A3, A2, A1, A0, 32'h0000_0001, 2, 32'h8000_0000, 7, 32'h81, 0, 1, 0, 0);
    // R7: close writes only dword 7; addresses ignored
    run("R7 close ok", 1, 0, 64'h5, 64'h7, 0, 0, 32'hFFFF_FFFF, 0, 0, 0, 32'h82, 2, 1, 0, 0);
    // R2: invalid operands
    run("R2 misaligned", 0, 0, A0, A1 | 64'h800, A2, A3, 0, 0, 0, 0, 32'h81, 0, 0, 1, 0);
    run("R2 wide vector", 0, 0, A0, A1, A2, A3, 32'h0001_0000, 0, 0, 0, 32'h81, 0, 0, 1, 0);
    // R9: protocol errors
    run("R9 wrong type", 0, 0, A0, A1, A2, A3, 5, 0, 0, 0, 32'h82, 1, 1, 3, 0);
    run("R9 newer version", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h8A, 1, 1, 3, 0);
    run("R9 direction zero", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'h02, 1, 1, 3, 0);
    run("R9 status nonzero", 0, 0, A0, A1, A2, A3, 9, 0, 0, 0, 32'h0000_0581, 1, 1, 3, 0);
    // R10: all-ones shortcut with and without flag
    run("R10 allones with flag", 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 2, 1, 0, 0);
    run("R10 allones no flag R4", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 2, 1, 2, 0);
    // R4: ownership never granted, gap 1, check latency
    run("R4 owner timeout", 0, 0, A0, A1, A2, A3, 0, 1, 32'h8000_0000, 0, 0, 0, 0, 2, 0);
    chk(done_cyc - start_cyc == 3 + 19999 * 2, "R4 timeout latency", done_cyc - start_cyc, 3 + 19999 * 2);
    // R11: start while busy ignored
    run("R11 start while busy", 0, 0, A0, A1, A2, A3, 32'h0000_1234, 0, 32'h8000_0000, 6, 32'h81, 2, 1, 0, 1);
    summary();
  end
endmodule